// File: doc/BRIEF.md
# Presettable Binary Counter with Dual Count Enables

This block is a synchronous up-counter, four bits wide by default. It can be preset from a parallel data bus, and it has two active-high count enables. The count advances only when both enables are high. Only the second enable, `en_t`, takes part in the terminal-count carry output, so several stages can share one clock and form a wider synchronous counter. In such a chain, each stage's `en_t` takes the carry of the stage below it.

A build-time parameter sets how the active-low reset behaves. With `ASYNC_RESET=1` it clears the count at once, with no clock edge. With `ASYNC_RESET=0` it takes effect at the next rising edge. The synchronous form can build a modulo-N counter: decode the last wanted state and feed the decode back into the reset, and the outputs stay free of glitches.

Top module: `preset_counter`

## Requirements
- R1: With ASYNC_RESET=1, a low `rst_n` forces `q` to 0 at once, with no clock edge, and holds it at 0 while `rst_n` stays low.
- R2: With ASYNC_RESET=0, a low `rst_n` leaves `q` unchanged until the next rising edge, which sets `q` to 0.
- R3: With `rst_n` high and `load_n` low, a rising edge copies `din` into `q`, whatever the values of `en_p` and `en_t`.
- R4: With `rst_n` and `load_n` high and both `en_p` and `en_t` high, each rising edge adds one to `q`.
- R5: With `rst_n` and `load_n` high, and `en_p` or `en_t` low, `q` keeps its value across the edge.
- R6: `rco` is high exactly when `en_t` is high and every bit of `q` is 1. `en_p` has no effect on `rco`.
- R7: Counting from the all-ones value returns `q` to 0 (15 to 0 for the 4-bit default).
- R8: Priority order: reset over load, load over count, count over hold. A low `rst_n` together with a low `load_n` gives 0.
- R9: Two synchronous 4-bit stages, with the high stage's `en_t` taken from the low stage's `rco`, count as one 8-bit counter that rolls from 255 to 0. The high stage's `rco` is high at 255 while the chain is enabled.
- R10: A load of all ones with `en_t` high makes `rco` high in the same cycle that the loaded value first appears on `q`.
- R11: A synchronous-reset counter whose `rst_n` is low whenever `q` equals 10 counts 0, 1, …, 10, 0 (modulo 11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_RESET |
| load_n | input | 1 | Active-low parallel preset |
| din | input | W | Preset value |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | W | Current count |
| rco | output | 1 | Terminal-count carry: en_t AND all bits of q |

## Verification
The bench gates the carry with `en_p` at the all-ones state. A design that lets `en_p` into the carry drops `rco` there, and that would stall a cascaded high stage. It asserts reset between clock edges, both to check that the asynchronous variant clears at once and to check that the synchronous variant waits for the edge. Getting the two swapped shows up as an early or late zero. It also checks load-versus-count and reset-versus-load priority, the 15-to-0 and 255-to-0 rollovers, the carry in the cycle right after a load of all ones, and the modulo-11 sequence. A wrong priority order or a carry taken from the registered next state would show up as a wrong value in one of those cycles.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    PC_HOLD  = 2'd0,
    PC_COUNT = 2'd1,
    PC_LOAD  = 2'd2,
    PC_CLEAR = 2'd3
  } pc_act_e;

  function automatic logic [31:0] pc_mask(input int unsigned w);
    logic [31:0] m;
    if (w >= 32) m = '1;
    else m = (32'd1 << w) - 32'd1;
    return m;
  endfunction

  function automatic logic [31:0] pc_inc(input logic [31:0] v, input int unsigned w);
    return (v + 32'd1) & pc_mask(w);
  endfunction

  function automatic logic pc_full(input logic [31:0] v, input int unsigned w);
    return (v & pc_mask(w)) == pc_mask(w);
  endfunction

  function automatic pc_act_e pc_choose(input logic rst_n, input logic load_n,
                                        input logic en_p, input logic en_t);
    pc_act_e a;
    if (!rst_n) a = PC_CLEAR;
    else if (!load_n) a = PC_LOAD;
    else if (en_p && en_t) a = PC_COUNT;
    else a = PC_HOLD;
    return a;
  endfunction

endpackage

// File: rtl/pc_decide.sv
module pc_decide
  import pc_pkg::*;
(
  input  logic    rst_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output pc_act_e act
);

  always_comb begin
    act = pc_choose(rst_n, load_n, en_p, en_t);
  end

endmodule

// File: rtl/pc_state.sv
module pc_state
  import pc_pkg::*;
#(
  parameter int unsigned W           = 4,
  parameter bit          ASYNC_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pc_act_e      act,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  always_comb begin
    unique case (act)
      PC_CLEAR: nxt = '0;
      PC_LOAD:  nxt = din;
      PC_COUNT: nxt = W'(pc_inc(32'(q), W));
      default:  nxt = q;
    endcase
  end

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/pc_carry.sv
module pc_carry
  import pc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q,
  input  logic         en_t,
  output logic         at_max,
  output logic         rco
);

  always_comb begin
    at_max = pc_full(32'(q), W);
    rco    = en_t & at_max;
  end

endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import pc_pkg::*;
#(
  parameter int unsigned W           = 4,
  parameter bit          ASYNC_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         rco
);

  pc_act_e act;
  logic    do_load;
  logic    do_count;
  logic    at_max;

  pc_decide u_decide (
    .rst_n  (rst_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .act    (act)
  );

  assign do_load  = (act == PC_LOAD);
  assign do_count = (act == PC_COUNT);

  pc_state #(.W(W), .ASYNC_RESET(ASYNC_RESET)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .din   (din),
    .q     (q)
  );

  pc_carry #(.W(W)) u_carry (
    .q      (q),
    .en_t   (en_t),
    .at_max (at_max),
    .rco    (rco)
  );

endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int unsigned W           = 4,
  parameter bit          ASYNC_RESET = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] q,
  input logic         rco,
  input logic         do_load,
  input logic         do_count,
  input logic         at_max
);

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !load_n) |=> (q == $past(din))); // R3

  AST_LOAD_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |-> !load_n); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1))); // R4

  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    do_count |-> (en_p && en_t && load_n)); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n && !(en_p && en_t)) |=> $stable(q)); // R5

  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rco |-> (en_t && at_max && (q == '1))); // R6

  AST_CARRY_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_t && (q == '1)) |-> rco); // R6

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_p && en_t && (q == '1)) |=> (q == '0)); // R7

  AST_LOAD_FULL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && (din == '1)) |=> (rco || !en_t)); // R10

  generate
    if (ASYNC_RESET) begin : g_async_chk
      AST_ASYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (q == '0)); // R1
    end else begin : g_sync_chk
      AST_SYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R2
    end
  endgenerate

endmodule

bind preset_counter preset_counter_chk #(.W(W), .ASYNC_RESET(ASYNC_RESET)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_n   (load_n),
  .din      (din),
  .en_p     (en_p),
  .en_t     (en_t),
  .q        (q),
  .rco      (rco),
  .do_load  (do_load),
  .do_count (do_count),
  .at_max   (at_max)
);

// File: tb/sim_preset_counter.sv
`timescale 1ns/1ps
module sim_preset_counter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       rst_a_n, rst_s_n, load_n, en_p, en_t;
  logic [3:0] din;
  logic [3:0] qa, qs;
  logic       rcoa, rcos;

  logic       c_rst_n, c_load_n, c_en;
  logic [7:0] c_din;
  logic [3:0] q_lo, q_hi;
  logic       rco_lo, rco_hi;

  logic       m_ext_n;
  logic [3:0] mq;
  logic       mrco;
  logic       m_rst_n;
  assign m_rst_n = m_ext_n & (mq != 4'd10);

  preset_counter #(.W(4), .ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rst_n(rst_a_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qa), .rco(rcoa));

  preset_counter #(.W(4), .ASYNC_RESET(1'b0)) u1 (
    .clk(clk), .rst_n(rst_s_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qs), .rco(rcos));

  preset_counter #(.W(4), .ASYNC_RESET(1'b0)) u_lo (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[3:0]),
    .en_p(c_en), .en_t(c_en), .q(q_lo), .rco(rco_lo));

  preset_counter #(.W(4), .ASYNC_RESET(1'b0)) u_hi (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[7:4]),
    .en_p(1'b1), .en_t(rco_lo), .q(q_hi), .rco(rco_hi));

  preset_counter #(.W(4), .ASYNC_RESET(1'b0)) u_mod (
    .clk(clk), .rst_n(m_rst_n), .load_n(1'b1), .din(4'd0),
    .en_p(1'b1), .en_t(1'b1), .q(mq), .rco(mrco));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset_state;
    chk("R1 async reset q", {4'd0, qa}, 8'd0);
    chk("R2 sync reset q", {4'd0, qs}, 8'd0);
    chk("R6 carry after reset", {7'd0, rcoa}, 8'd0);
  endtask

  task automatic t_load_priority;
    load_n = 0; din = 4'd9; en_p = 0; en_t = 0;
    tick;
    chk("R3 load with enables low (async)", {4'd0, qa}, 8'd9);
    chk("R3 load with enables low (sync)", {4'd0, qs}, 8'd9);
    en_p = 1; en_t = 1; din = 4'd5;
    tick;
    chk("R8 load beats count", {4'd0, qa}, 8'd5);
    rst_s_n = 0; din = 4'd7;
    tick;
    chk("R8 reset beats load", {4'd0, qs}, 8'd0);
    chk("R3 load unaffected elsewhere", {4'd0, qa}, 8'd7);
    rst_s_n = 1; en_p = 0; en_t = 0;
  endtask

  task automatic t_count_hold;
    load_n = 0; din = 4'd0;
    tick;
    load_n = 1; en_p = 1; en_t = 1;
    for (int k = 1; k <= 3; k++) begin
      tick;
      chk("R4 increment async", {4'd0, qa}, 8'(k));
      chk("R4 increment sync", {4'd0, qs}, 8'(k));
    end
    en_p = 0;
    tick;
    chk("R5 hold with en_p low", {4'd0, qa}, 8'd3);
    en_p = 1; en_t = 0;
    tick;
    chk("R5 hold with en_t low", {4'd0, qs}, 8'd3);
  endtask

  task automatic t_wrap_carry;
    load_n = 0; din = 4'd15; en_t = 1; en_p = 0;
    tick;
    chk("R10 loaded value", {4'd0, qa}, 8'd15);
    chk("R10 carry with new value", {7'd0, rcoa}, 8'd1);
    chk("R10 carry sync variant", {7'd0, rcos}, 8'd1);
    load_n = 1;
    en_p = 1; #1;
    chk("R6 carry with en_p high", {7'd0, rcoa}, 8'd1);
    en_p = 0; #1;
    chk("R6 carry with en_p low", {7'd0, rcoa}, 8'd1);
    en_t = 0; #1;
    chk("R6 carry drops with en_t", {7'd0, rcoa}, 8'd0);
    en_t = 1; en_p = 1;
    tick;
    chk("R7 wrap async", {4'd0, qa}, 8'd0);
    chk("R7 wrap sync", {4'd0, qs}, 8'd0);
    chk("R6 carry after wrap", {7'd0, rcoa}, 8'd0);
  endtask

  task automatic t_async_reset;
    tick;
    #1 rst_a_n = 0;
    #1;
    chk("R1 cleared before edge", {4'd0, qa}, 8'd0);
    chk("R1 sync part untouched", {4'd0, qs}, 8'd1);
    tick;
    chk("R1 held while low", {4'd0, qa}, 8'd0);
    rst_a_n = 1;
  endtask

  task automatic t_sync_reset;
    tick;
    chk("R4 sync continues", {4'd0, qs}, 8'd3);
    rst_s_n = 0; #1;
    chk("R2 unchanged before edge", {4'd0, qs}, 8'd3);
    tick;
    chk("R2 cleared at edge", {4'd0, qs}, 8'd0);
    tick;
    chk("R2 stays cleared", {4'd0, qs}, 8'd0);
    rst_s_n = 1; en_p = 0; en_t = 0;
  endtask

  task automatic t_cascade;
    c_load_n = 0; c_din = 8'hFD; c_en = 0;
    tick;
    chk("R9 chain load", {q_hi, q_lo}, 8'hFD);
    c_load_n = 1; c_en = 1;
    tick;
    chk("R9 chain count", {q_hi, q_lo}, 8'hFE);
    tick;
    chk("R9 chain at 255", {q_hi, q_lo}, 8'hFF);
    chk("R9 high carry at 255", {7'd0, rco_hi}, 8'd1);
    tick;
    chk("R9 chain rollover", {q_hi, q_lo}, 8'h00);
    chk("R9 high carry after rollover", {7'd0, rco_hi}, 8'd0);
    c_load_n = 0; c_din = 8'h0F; c_en = 0;
    tick;
    c_load_n = 1; c_en = 1;
    tick;
    chk("R9 low carry into high stage", {q_hi, q_lo}, 8'h10);
    c_en = 0;
  endtask

  task automatic t_modulo;
    m_ext_n = 0;
    tick;
    m_ext_n = 1;
    chk("R11 modulo start", {4'd0, mq}, 8'd0);
    for (int i = 1; i <= 13; i++) begin
      tick;
      chk("R11 modulo-11 sequence", {4'd0, mq}, 8'(i % 11));
    end
  endtask

  initial begin
    rst_a_n = 0; rst_s_n = 0; load_n = 1; din = 4'd0; en_p = 0; en_t = 0;
    c_rst_n = 0; c_load_n = 1; c_din = 8'd0; c_en = 0;
    m_ext_n = 0;
    tick;
    tick;
    t_reset_state;
    rst_a_n = 1; rst_s_n = 1; c_rst_n = 1;
    t_load_priority;
    t_count_hold;
    t_wrap_carry;
    t_async_reset;
    t_sync_reset;
    t_cascade;
    t_modulo;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule